// File: doc/BRIEF.md
# SPI Master Shifter with Double-Buffered Transmit and Receive

This block is the master side of a full-duplex, byte-wide SPI link. Software, or a local state machine, writes a byte into a one-entry transmit holding register. As soon as the shifter is free, the byte moves into the shift register and eight bits are clocked out on MOSI. At the same time eight bits are clocked in from MISO. The received byte lands in a one-entry receive holding register. While that happens, the transmit holding register is free again and can take the next byte, so a stream of bytes can run with no gap on the serial clock.

Static controls set the idle level of the serial clock and the edge on which MISO is sampled (MOSI changes on the other edge). They also set the bit order and choose which event drives the interrupt line: the transmit holding register becoming free, or a byte finishing. The serial clock runs at one quarter of the system clock, because each half-period lasts two system cycles. It moves only while the block is enabled. An 8-bit status word reports the buffer states and two sticky events. A chip-select output simply follows a software control bit.

Top module: `spim_shifter_top`

## Requirements
- R1: During a transfer, each half-period of SCLK lasts exactly two system clock cycles. A byte spans 16 half-periods (32 cycles). The first SCLK edge comes two cycles after the cycle in which the byte enters the shifter.
- R2: SCLK stays at its idle level whenever no transfer is in progress or `cfg_en` is low. Lowering `cfg_en` abandons a transfer in progress without setting any completion flag.
- R3: `cfg_cpol` = 0 gives an SCLK that idles low; `cfg_cpol` = 1 gives an SCLK that idles high.
- R4: With `cfg_late` = 0, MISO is sampled on each leading (first-from-idle) SCLK edge and MOSI changes on trailing edges. With `cfg_late` = 1, MISO is sampled on trailing edges and MOSI changes on leading edges. In both cases the first bit is on MOSI from the cycle the byte enters the shifter. MOSI is 0 when no transfer runs.
- R5: A write (`tx_wr`) is accepted only while status bit 4 (transmit holding empty) is 1; otherwise it is ignored. With `cfg_en` = 1, a held byte enters the shifter on the first cycle the shifter is free, and bit 4 returns to 1.
- R6: `cfg_lsb` = 0 sends and receives the most significant bit first; `cfg_lsb` = 1 sends and receives the least significant bit first.
- R7: When the last edge of a byte passes, `rx_data` takes the received byte, status bit 3 (receive full) and bit 5 (byte done) are set. `rx_rd` clears bit 3, `stat_rd` clears bits 5 and 6, and a set in the same cycle wins. Status bits 0, 1, 2 and 7 are always 0.
- R8: Status bit 6 (overrun) is set when a byte completes while bit 3 is 1 and `rx_rd` is not asserted in that cycle. The new byte replaces the old one.
- R9: `irq` equals `cfg_en` AND (`cfg_irq_done` ? bit 5 : bit 4).
- R10: If the transmit holding register is full when a byte completes, the next byte starts in the same cycle, with no idle SCLK half-period in between.
- R11: `ss_n` is the inverse of `ss_ctl`, registered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enable; low stops SCLK and abandons a transfer |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_late | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb | input | 1 | 0: MSB first, 1: LSB first |
| cfg_irq_done | input | 1 | Interrupt source: 0 transmit-empty, 1 byte-done |
| ss_ctl | input | 1 | Software chip-select request |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to send |
| rx_rd | input | 1 | Read strobe; clears receive-full |
| stat_rd | input | 1 | Status read strobe; clears byte-done and overrun |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low chip select |
| irq | output | 1 | Interrupt level |
| status | output | 8 | Flags: bit3 rx full, bit4 tx empty, bit5 done, bit6 overrun |
| rx_data | output | 8 | Last received byte |

## Verification
A write is registered at the next edge, the byte enters the shifter one edge later, SCLK first moves two cycles after that, and the done and receive flags follow 32 cycles after entry. The bench keeps a behavioural model that advances on the same clock edge as the design, holding a per-transfer cycle count and a queue for the held byte. Every output is compared half a period after each edge, so each result is checked in the very cycle it is due and never with a tolerance. Controls change only between transfers, and all stimulus is driven one time step after the rising edge.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int STAT_W       = 8;
  localparam int ST_RX_FULL   = 3;
  localparam int ST_TX_EMPTY  = 4;
  localparam int ST_DONE      = 5;
  localparam int ST_OVERRUN   = 6;

  typedef enum logic {ORDER_MSB = 1'b0, ORDER_LSB = 1'b1} order_e;
endpackage

// File: rtl/spim_edge_gen.sv
module spim_edge_gen #(
  parameter  int HALF_EDGES = 16,
  localparam int CNT_W      = $clog2(HALF_EDGES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  output logic busy,
  output logic phase,
  output logic lead_ev,
  output logic trail_ev,
  output logic first_half,
  output logic last_ev
);
  logic             busy_q, busy_d;
  logic             div_q, div_d;
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] hc_q, hc_d;
  logic             tick;

  assign tick       = en & busy_q & div_q;
  assign lead_ev    = tick & ~hc_q[0];
  assign trail_ev   = tick & hc_q[0];
  assign first_half = (hc_q == '0);
  assign last_ev    = trail_ev & (hc_q == CNT_W'(HALF_EDGES - 1));
  assign busy       = busy_q;
  assign phase      = ph_q;

  always_comb begin
    busy_d = busy_q;
    div_d  = div_q;
    ph_d   = ph_q;
    hc_d   = hc_q;
    if (!en) begin
      busy_d = 1'b0;
      div_d  = 1'b0;
      ph_d   = 1'b0;
      hc_d   = '0;
    end else if (start) begin
      busy_d = 1'b1;
      div_d  = 1'b0;
      ph_d   = 1'b0;
      hc_d   = '0;
    end else if (busy_q) begin
      div_d = ~div_q;
      if (div_q) begin
        ph_d = ~ph_q;
        hc_d = hc_q + 1'b1;
        if (hc_q == CNT_W'(HALF_EDGES - 1)) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      div_q  <= 1'b0;
      ph_q   <= 1'b0;
      hc_q   <= '0;
    end else begin
      busy_q <= busy_d;
      div_q  <= div_d;
      ph_q   <= ph_d;
      hc_q   <= hc_d;
    end
  end

  AST_HALF_PERIOD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && ph_q != $past(ph_q)) |=> (ph_q == $past(ph_q)) || !en); // R1

  AST_PHASE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !ph_q); // R2
endmodule

// File: rtl/spim_shift_core.sv
module spim_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              lsb_first,
  input  logic              late,
  input  logic              busy,
  input  logic              lead_ev,
  input  logic              trail_ev,
  input  logic              first_half,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_next
);
  logic [DATA_W-1:0] tx_sh_q, tx_sh_d;
  logic [DATA_W-1:0] rx_sh_q;
  logic              shift_ev, samp_ev, out_bit;

  assign shift_ev = late ? (lead_ev & ~first_half) : trail_ev;
  assign samp_ev  = late ? trail_ev : lead_ev;
  assign out_bit  = lsb_first ? tx_sh_q[0] : tx_sh_q[DATA_W-1];
  assign mosi     = busy & out_bit;

  always_comb begin
    tx_sh_d = tx_sh_q;
    if (load) begin
      tx_sh_d = load_data;
    end else if (shift_ev) begin
      tx_sh_d = lsb_first ? {1'b0, tx_sh_q[DATA_W-1:1]} : {tx_sh_q[DATA_W-2:0], 1'b0};
    end
  end

  always_comb begin
    rx_next = rx_sh_q;
    if (samp_ev) begin
      rx_next = lsb_first ? {miso, rx_sh_q[DATA_W-1:1]} : {rx_sh_q[DATA_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else begin
      tx_sh_q <= tx_sh_d;
      if (samp_ev) rx_sh_q <= rx_next;
    end
  end

  AST_NO_SAMPLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(lead_ev || trail_ev)); // R4
endmodule

// File: rtl/spim_buf_ctl.sv
module spim_buf_ctl
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              irq_on_done,
  input  logic              ss_ctl,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  input  logic              stat_rd,
  input  logic              busy,
  input  logic              last_ev,
  input  logic [DATA_W-1:0] rx_next,
  output logic              start,
  output logic [DATA_W-1:0] tx_hold,
  output logic [DATA_W-1:0] rx_data,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              ss_n
);
  logic              tx_full_q, tx_full_d;
  logic [DATA_W-1:0] tx_buf_q, tx_buf_d;
  logic              rx_full_q, rx_full_d;
  logic [DATA_W-1:0] rx_buf_q, rx_buf_d;
  logic              done_q, done_d;
  logic              ovr_q, ovr_d;
  logic              ss_q;
  logic              wr_ok;

  assign start = en & tx_full_q & (~busy | last_ev);
  assign wr_ok = tx_wr & ~tx_full_q;

  always_comb begin
    tx_full_d = tx_full_q;
    tx_buf_d  = tx_buf_q;
    if (start) tx_full_d = 1'b0;
    if (wr_ok) begin
      tx_full_d = 1'b1;
      tx_buf_d  = tx_data;
    end
  end

  always_comb begin
    rx_full_d = rx_full_q;
    rx_buf_d  = rx_buf_q;
    done_d    = done_q;
    ovr_d     = ovr_q;
    if (rx_rd)   rx_full_d = 1'b0;
    if (stat_rd) begin
      done_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (last_ev) begin
      rx_buf_d  = rx_next;
      rx_full_d = 1'b1;
      done_d    = 1'b1;
      if (rx_full_q && !rx_rd) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full_q <= 1'b0;
      tx_buf_q  <= '0;
      rx_full_q <= 1'b0;
      rx_buf_q  <= '0;
      done_q    <= 1'b0;
      ovr_q     <= 1'b0;
      ss_q      <= 1'b1;
    end else begin
      tx_full_q <= tx_full_d;
      if (wr_ok)   tx_buf_q <= tx_buf_d;
      rx_full_q <= rx_full_d;
      if (last_ev) rx_buf_q <= rx_buf_d;
      done_q    <= done_d;
      ovr_q     <= ovr_d;
      ss_q      <= ~ss_ctl;
    end
  end

  always_comb begin
    status              = '0;
    status[ST_RX_FULL]  = rx_full_q;
    status[ST_TX_EMPTY] = ~tx_full_q;
    status[ST_DONE]     = done_q;
    status[ST_OVERRUN]  = ovr_q;
  end

  assign tx_hold = tx_buf_q;
  assign rx_data = rx_buf_q;
  assign irq     = en & (irq_on_done ? done_q : ~tx_full_q);
  assign ss_n    = ss_q;

  AST_START_FREES_TX: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !tx_full_q); // R5

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full_q) |=> $stable(tx_buf_q)); // R5

  AST_RX_FULL_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> rx_full_q && done_q); // R7

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_full_q)); // R8
endmodule

// File: rtl/spim_shifter_top.sv
module spim_shifter_top
  import spim_pkg::*;
#(
  parameter  int DATA_W     = 8,
  localparam int HALF_EDGES = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_cpol,
  input  logic              cfg_late,
  input  logic              cfg_lsb,
  input  logic              cfg_irq_done,
  input  logic              ss_ctl,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  input  logic              stat_rd,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              ss_n,
  output logic              irq,
  output logic [STAT_W-1:0] status,
  output logic [DATA_W-1:0] rx_data
);
  logic              busy, phase, lead_ev, trail_ev, first_half, last_ev, start;
  logic [DATA_W-1:0] tx_hold, rx_next;

  spim_edge_gen #(.HALF_EDGES(HALF_EDGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .start(start),
    .busy(busy), .phase(phase), .lead_ev(lead_ev), .trail_ev(trail_ev),
    .first_half(first_half), .last_ev(last_ev)
  );

  spim_shift_core #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_data(tx_hold),
    .lsb_first(cfg_lsb), .late(cfg_late), .busy(busy),
    .lead_ev(lead_ev), .trail_ev(trail_ev), .first_half(first_half),
    .miso(miso), .mosi(mosi), .rx_next(rx_next)
  );

  spim_buf_ctl #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .irq_on_done(cfg_irq_done),
    .ss_ctl(ss_ctl), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
    .stat_rd(stat_rd), .busy(busy), .last_ev(last_ev), .rx_next(rx_next),
    .start(start), .tx_hold(tx_hold), .rx_data(rx_data), .status(status),
    .irq(irq), .ss_n(ss_n)
  );

  assign sclk = cfg_cpol ^ (cfg_en & phase);

  AST_CHAIN_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (last_ev && start) |=> busy); // R10
endmodule

// File: tb/tb_spim_shifter_top.sv
module tb_spim_shifter_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0, cfg_cpol = 1'b0, cfg_late = 1'b0, cfg_lsb = 1'b0, cfg_irq_done = 1'b0;
  logic       ss_ctl = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, stat_rd = 1'b0, miso = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       sclk, mosi, ss_n, irq;
  logic [7:0] status, rx_data;

  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  spim_shifter_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_late(cfg_late),
    .cfg_lsb(cfg_lsb), .cfg_irq_done(cfg_irq_done), .ss_ctl(ss_ctl), .tx_wr(tx_wr),
    .tx_data(tx_data), .rx_rd(rx_rd), .stat_rd(stat_rd), .miso(miso), .sclk(sclk),
    .mosi(mosi), .ss_n(ss_n), .irq(irq), .status(status), .rx_data(rx_data)
  );

  always #4 clk = ~clk;

  // Behavioural reference: transfer progress as a cycle count since the byte entered
  logic       m_busy, m_txf, m_rxf, m_done, m_ovr, m_ss;
  int         m_c;
  logic [7:0] m_cur, m_rxbuf;
  logic [7:0] m_txq[$];
  logic       m_bits[8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_txf = 0; m_rxf = 0; m_done = 0; m_ovr = 0; m_ss = 1; m_c = 0;
      m_cur = 0; m_rxbuf = 0; m_txq.delete();
    end else begin
      logic txf_old, rxf_old;
      txf_old = m_txf;
      rxf_old = m_rxf;
      if (rx_rd) m_rxf = 0;
      if (stat_rd) begin m_done = 0; m_ovr = 0; end
      if (!cfg_en) begin
        m_busy = 0; m_c = 0;
      end else if (m_busy) begin
        m_c++;
        if (!cfg_late && (m_c % 4) == 2) m_bits[(m_c - 2) / 4] = miso;
        if (cfg_late && (m_c % 4) == 0) m_bits[m_c / 4 - 1] = miso;
        if (m_c == 32) begin
          for (int k = 0; k < 8; k++) begin
            if (cfg_lsb) m_rxbuf[k] = m_bits[k];
            else m_rxbuf[7 - k] = m_bits[k];
          end
          if (rxf_old && !rx_rd) m_ovr = 1;
          m_rxf = 1; m_done = 1;
          if (txf_old) begin
            m_cur = m_txq.pop_front(); m_txf = 0; m_c = 0;
          end else begin
            m_busy = 0; m_c = 0;
          end
        end
      end else if (txf_old) begin
        m_cur = m_txq.pop_front(); m_txf = 0; m_busy = 1; m_c = 0;
      end
      if (tx_wr && !txf_old) begin
        m_txq.push_back(tx_data); m_txf = 1;
      end
      m_ss = ~ss_ctl;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_sclk, e_mosi, e_irq;
      logic [7:0] e_stat;
      int idx;
      e_sclk = (m_busy && cfg_en) ? (cfg_cpol ^ ((m_c / 2) % 2 == 1)) : cfg_cpol;
      if (cfg_late) idx = (m_c < 2) ? 0 : (m_c - 2) / 4;
      else idx = m_c / 4;
      e_mosi = m_busy ? (cfg_lsb ? m_cur[idx] : m_cur[7 - idx]) : 1'b0;
      e_stat = {1'b0, m_ovr, m_done, ~m_txf, m_rxf, 3'b000};
      e_irq  = cfg_en & (cfg_irq_done ? m_done : ~m_txf);
      chk("R1/R2/R3/R10 sclk", {7'd0, sclk}, {7'd0, e_sclk});
      chk("R4/R6 mosi", {7'd0, mosi}, {7'd0, e_mosi});
      chk("R5/R7/R8 status", status, e_stat);
      chk("R6/R7 rx_data", rx_data, m_rxbuf);
      chk("R9 irq", {7'd0, irq}, {7'd0, e_irq});
      chk("R11 ss_n", {7'd0, ss_n}, {7'd0, m_ss});
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[15];
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    step(1); tx_wr = 1; tx_data = d;
    step(1); tx_wr = 0;
  endtask

  task automatic pulse_rx_rd();
    step(1); rx_rd = 1; step(1); rx_rd = 0;
  endtask

  task automatic pulse_stat_rd();
    step(1); stat_rd = 1; step(1); stat_rd = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    @(negedge clk);
    // reset state: tx empty only, clock idle low, no interrupt while disabled
    chk("R7 reset status", status, 8'h10);
    chk("R2 reset sclk", {7'd0, sclk}, 8'h00);
    chk("R4 reset mosi", {7'd0, mosi}, 8'h00);
    chk("R9 reset irq", {7'd0, irq}, 8'h00);
    chk("R11 reset ss_n", {7'd0, ss_n}, 8'h01);

    // R6 R4: msb first, leading-edge sampling, idle low
    step(1); cfg_en = 1; ss_ctl = 1;
    wr(8'hA5);
    step(40);
    pulse_rx_rd();
    pulse_stat_rd();

    // R3 R4 R6 R10 R8: idle high, trailing-edge sampling, lsb first, chained bytes
    step(1); cfg_cpol = 1; cfg_late = 1; cfg_lsb = 1;
    wr(8'h3C);
    step(3);
    wr(8'hC3);
    step(80);
    pulse_stat_rd();
    pulse_rx_rd();

    // R5: third write while holding register is full is ignored
    step(1); cfg_cpol = 0; cfg_late = 1; cfg_lsb = 0;
    wr(8'h11);
    wr(8'h22);
    wr(8'h33);
    step(100);
    pulse_rx_rd();
    pulse_stat_rd();

    // R9: interrupt follows byte-done
    step(1); cfg_irq_done = 1; cfg_cpol = 1; cfg_late = 0;
    wr(8'h5A);
    step(40);
    pulse_stat_rd();
    step(2);

    // R2: disable mid-transfer stops the clock and abandons the byte
    wr(8'hF0);
    step(10);
    cfg_en = 0;
    step(10);
    cfg_en = 1;
    step(6);

    // R11: chip select follows control
    ss_ctl = 0; step(3); ss_ctl = 1; step(3);
    @(negedge clk);
    finish_run();
  end
endmodule